// File: doc/BRIEF.md
# Byte Sequence Detector with Reply

This block sits on an 8-bit bidirectional bus and watches for a fixed three-byte pattern. While it listens, it takes one byte from the bus at every rising clock edge. The pattern is 0x00, then 0x11, then 0x22, with each byte taken on the next edge after the one before. When the third byte arrives, the block takes over the bus for two clocks. It drives 0xAA and then 0xBB. After that it releases the bus and starts listening again from scratch.

One explicit state machine makes every decision. The reply ends in a state transition, so the match indication cannot stay set once the reply is over. A separate output-enable shows when the block owns the bus. A one-cycle done pulse marks the final reply byte. Another agent on the bus can use the output-enable to know when it must stop driving.

Top module: `seq_reply_unit`

## Requirements
- R1: When `rst_ni` is low, `bus_oe_o` and `done_o` go low at once, without waiting for a clock edge, and the bus is released. This also holds in the middle of a reply. After reset is released, a full new pattern is needed before any reply.
- R2: Suppose the block is listening and samples 0x00, 0x11 and 0x22 on three consecutive rising edges. Then after the edge that sampled 0x22, `bus_oe_o` is high and the bus carries 0xAA.
- R3: In the next cycle after the 0xAA cycle, `bus_oe_o` stays high, the bus carries 0xBB, and `done_o` is high. `done_o` is high in no other cycle.
- R4: After the 0xBB cycle, `bus_oe_o` is low and the block is listening. Bytes seen before the reply do not count toward the next match, so 0x11, 0x22 arriving after a reply produce no reply.
- R5: If a sampled byte breaks the pattern, no reply follows. A breaking byte equal to 0x00 counts as a new first byte, so 0x00 0x00 0x11 0x22 and 0x00 0x11 0x00 0x11 0x22 each produce a reply. Any other breaking byte restarts the search.
- R6: Whenever the block is not in its two reply cycles, `bus_oe_o` is low, `done_o` is low, and the bus is at high impedance from the block's side.
- R7: A pattern that starts on the first listening cycle after a reply is detected. Consecutive patterns therefore give consecutive replies with no extra idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_io | inout | 8 | Shared data bus; sampled while listening, driven during the reply |
| bus_oe_o | output | 1 | High while the block drives the bus |
| done_o | output | 1 | One-cycle pulse during the final reply byte |

## Verification
Two situations are hardest to reach from the ports. The first is a reset that arrives while the block itself is driving the bus. The bench creates it by completing a pattern, waiting until the falling edge inside the 0xAA cycle, and then pulling reset low. At that point it checks the output-enable with no clock edge in between. The second is a bus handover with no gap between pattern bytes and reply. The bench stops driving one nanosecond after the edge that samples 0x22, and starts driving again on the falling edge after the 0xBB cycle. This lets it issue back-to-back patterns at the fastest rate the block allows.

// File: rtl/seq_reply_pkg.sv
`timescale 1ns/1ps
package seq_reply_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PAT_LEN = 3;
  localparam int unsigned RPL_LEN = 2;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GOT0  = 3'd1,
    ST_GOT1  = 3'd2,
    ST_SEND0 = 3'd3,
    ST_SEND1 = 3'd4
  } state_e;
endpackage

// File: rtl/seq_byte_match.sv
`timescale 1ns/1ps
module seq_byte_match
  import seq_reply_pkg::*;
#(
  parameter logic [PAT_LEN-1:0][BYTE_W-1:0] PATTERN = {8'h22, 8'h11, 8'h00}
) (
  input  byte_t              byte_i,
  output logic [PAT_LEN-1:0] hit_o
);
  // one comparator per pattern position
  for (genvar g = 0; g < PAT_LEN; g++) begin : g_cmp
    assign hit_o[g] = (byte_i == PATTERN[g]);
  end
endmodule

// File: rtl/seq_ctrl_fsm.sv
`timescale 1ns/1ps
module seq_ctrl_fsm
  import seq_reply_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PAT_LEN-1:0] hit_i,
  output state_e             state_o
);
  state_e state_q, state_d;

  // mismatch fallback: a first-byte hit restarts the pattern
  logic [2:0] restart;
  assign restart = hit_i[0] ? 3'(ST_GOT0) : 3'(ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  state_d = hit_i[0] ? ST_GOT0 : ST_IDLE;
      ST_GOT0:  state_d = hit_i[1] ? ST_GOT1 : state_e'(restart);
      ST_GOT1:  state_d = hit_i[2] ? ST_SEND0 : state_e'(restart);
      ST_SEND0: state_d = ST_SEND1;   // bus input ignored
      ST_SEND1: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/seq_reply_drive.sv
`timescale 1ns/1ps
module seq_reply_drive
  import seq_reply_pkg::*;
#(
  parameter logic [RPL_LEN-1:0][BYTE_W-1:0] REPLY = {8'hBB, 8'hAA}
) (
  input  state_e state_i,
  output byte_t  data_o,
  output logic   oe_o,
  output logic   done_o
);
  always_comb begin
    oe_o   = 1'b0;
    done_o = 1'b0;
    data_o = '0;
    unique case (state_i)
      ST_SEND0: begin
        oe_o   = 1'b1;
        data_o = REPLY[0];
      end
      ST_SEND1: begin
        oe_o   = 1'b1;
        done_o = 1'b1;
        data_o = REPLY[1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/seq_reply_unit.sv
`timescale 1ns/1ps
module seq_reply_unit
  import seq_reply_pkg::*;
#(
  parameter logic [PAT_LEN-1:0][BYTE_W-1:0] PATTERN = {8'h22, 8'h11, 8'h00},
  parameter logic [RPL_LEN-1:0][BYTE_W-1:0] REPLY   = {8'hBB, 8'hAA}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  inout  wire  [7:0] bus_io,
  output logic       bus_oe_o,
  output logic       done_o
);
  byte_t              bus_s;
  byte_t              drv_data;
  logic [PAT_LEN-1:0] hit;
  state_e             state_q;

  assign bus_s = bus_io;

  seq_byte_match #(.PATTERN(PATTERN)) u_match (
    .byte_i (bus_s),
    .hit_o  (hit)
  );

  seq_ctrl_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .state_o (state_q)
  );

  seq_reply_drive #(.REPLY(REPLY)) u_drive (
    .state_i (state_q),
    .data_o  (drv_data),
    .oe_o    (bus_oe_o),
    .done_o  (done_o)
  );

  assign bus_io = bus_oe_o ? drv_data : 8'hzz;
endmodule

// File: rtl/seq_reply_unit_chk.sv
`timescale 1ns/1ps
module seq_reply_unit_chk
  import seq_reply_pkg::*;
#(
  parameter logic [PAT_LEN-1:0][BYTE_W-1:0] PATTERN = {8'h22, 8'h11, 8'h00},
  parameter logic [RPL_LEN-1:0][BYTE_W-1:0] REPLY   = {8'hBB, 8'hAA}
) (
  input logic   clk_i,
  input logic   rst_ni,
  input byte_t  bus_i,
  input logic   oe_i,
  input logic   done_i,
  input state_e state_i
);
  a_r1_reset_release: assert property (@(posedge clk_i)
    !rst_ni |-> (!oe_i && !done_i));

  a_r2_detect_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_GOT1 && !oe_i && bus_i == PATTERN[2]) |=> (oe_i && bus_i == REPLY[0]));

  a_r3_second_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && !done_i) |=> (oe_i && done_i && bus_i == REPLY[1]));

  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r4_release_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (!oe_i && state_i == ST_IDLE));

  a_r5_break_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_GOT0 && !oe_i && bus_i != PATTERN[1] && bus_i != PATTERN[0])
      |=> (state_i == ST_IDLE));

  a_r6_done_needs_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> oe_i);
endmodule

bind seq_reply_unit seq_reply_unit_chk #(.PATTERN(PATTERN), .REPLY(REPLY)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .bus_i   (bus_io),
  .oe_i    (bus_oe_o),
  .done_i  (done_o),
  .state_i (state_q)
);

// File: tb/seq_reply_unit_tb_top.sv
`timescale 1ns/1ps
module seq_reply_unit_tb_top;
  logic       clk   = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_oe = 1'b1;
  logic [7:0] tb_data = 8'h55;
  wire  [7:0] bus_w;
  logic       oe, done;

  assign bus_w = tb_oe ? tb_data : 8'hzz;

  seq_reply_unit dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .bus_io   (bus_w),
    .bus_oe_o (oe),
    .done_o   (done)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic       oe;
    logic [7:0] d;
    logic       done;
    string      req;
  } exp_t;

  exp_t sb_q[$];
  int   n_run = 0, n_fail = 0;
  int   reply_left = 0;
  logic [7:0] h0 = 8'hFF, h1 = 8'hFF, h2 = 8'hFF;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic o, input logic [7:0] d, input logic dn, input string req);
    exp_t e;
    e.oe = o; e.d = d; e.done = dn; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic clear_hist();
    h0 = 8'hFF; h1 = 8'hFF; h2 = 8'hFF;
  endtask

  // driver: finishes any reply in progress, then presents one byte
  task automatic send(input logic [7:0] b, input string req);
    while (reply_left > 0) begin
      @(negedge clk);
      tb_oe = 1'b0;
      if (reply_left == 2) push(1'b1, 8'hBB, 1'b1, "R3");
      else                 push(1'b0, 8'h00, 1'b0, "R4");
      reply_left--;
      if (reply_left == 0) clear_hist();
    end
    @(negedge clk);
    tb_oe = 1'b1;
    tb_data = b;
    h0 = h1; h1 = h2; h2 = b;
    if (h0 == 8'h00 && h1 == 8'h11 && h2 == 8'h22) begin
      push(1'b1, 8'hAA, 1'b0, req);
      reply_left = 2;
      @(posedge clk);
      #1 tb_oe = 1'b0;     // hand the bus over
    end else begin
      push(1'b0, 8'h00, 1'b0, req);
    end
  endtask

  // monitor: pops one expected item per cycle
  always begin
    @(posedge clk);
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(oe == e.oe, e.oe ? e.req : "R6", "oe", int'(oe), int'(e.oe));
      check(done == e.done, e.done ? "R3" : "R6", "done", int'(done), int'(e.done));
      if (e.oe) check(bus_w == e.d, e.req, "bus", int'(bus_w), int'(e.d));
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(oe == 1'b0, "R1", "oe in reset", int'(oe), 0);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;

    // R2 R3 R4: basic detection and reply
    send(8'h00, "R2"); send(8'h11, "R2"); send(8'h22, "R2");
    send(8'h55, "R4");
    // R4: stale bytes do not carry across a reply
    send(8'h00, "R4"); send(8'h11, "R4"); send(8'h22, "R4");
    send(8'h11, "R4"); send(8'h22, "R4"); send(8'h55, "R4");

    // R5: broken patterns
    send(8'h00, "R5"); send(8'h11, "R5"); send(8'h33, "R5"); send(8'h22, "R5");
    send(8'h00, "R5"); send(8'h22, "R5");
    send(8'h11, "R5"); send(8'h22, "R5");
    // R5: 0x00 restarts
    send(8'h00, "R5"); send(8'h00, "R5"); send(8'h11, "R5"); send(8'h22, "R5");
    send(8'h00, "R5"); send(8'h11, "R5"); send(8'h00, "R5"); send(8'h11, "R5");
    send(8'h22, "R5");

    // R7: back-to-back patterns
    for (int i = 0; i < 3; i++) begin
      send(8'h00, "R7"); send(8'h11, "R7"); send(8'h22, "R7");
    end
    send(8'h5A, "R6"); send(8'hAA, "R6"); send(8'hBB, "R6");

    // R1: asynchronous reset during the reply
    send(8'h00, "R1"); send(8'h11, "R1"); send(8'h22, "R1");
    @(negedge clk);
    check(oe == 1'b1, "R1", "oe before reset", int'(oe), 1);
    rst_n = 1'b0;
    #1;
    check(oe == 1'b0, "R1", "oe async reset", int'(oe), 0);
    check(done == 1'b0, "R1", "done async reset", int'(done), 0);
    tb_oe = 1'b1; tb_data = 8'h55;
    reply_left = 0;
    clear_hist();
    @(negedge clk);
    rst_n = 1'b1;
    send(8'h11, "R1"); send(8'h22, "R1");
    send(8'h00, "R1"); send(8'h11, "R1"); send(8'h22, "R1");
    send(8'h55, "R6"); send(8'h55, "R6");
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule